// File: doc/BRIEF.md
# Indexed-Access Prioritized Interrupt Controller

This block gathers a bank of system interrupt inputs and funnels them into one host interrupt line. Each input is conditioned by its own polarity and trigger-type settings and then produces a raw status bit. An input is a candidate when its status is set and its enable is set. Among the candidates, an arbiter picks a winner using a per-input channel number. A lower channel means higher priority, and ties go to the lowest input number.

Software uses a plain 32-bit register bus with address, write strobe, read strobe, write data and read data. A write takes effect on the clock edge where `bus_wr` is high. Read data is combinational while `bus_rd` is high and is zero otherwise. Enables and status can be changed in two ways:
- by writing an input number to an indexed register, which acts on that single input;
- by write-one-to-clear bitmask words, 32 inputs per word.

A read-only index register reports the current winner, or a "none" flag.

Top module: `idx_intc`

## Requirements
- R1: After reset the controller is in its default state:
  - all enables are 0, all status bits are 0, and the global and host-line enables are 0;
  - every channel field is 7, every polarity bit is 1 and every type bit is 0;
  - the index register at 0x80 reads 0x80000000 and `host_irq` is 0.
- R2: A level-type input (type bit 0) shows status 1 while its synchronised input equals its polarity bit, and 0 otherwise. Polarity 1 means active high and 0 means active low. Status for inputs 32n..32n+31 reads at 0x280+4n, with bit i%32 for input i. The input passes through two synchroniser flops, so status follows it within four clocks.
- R3: An edge-type input (type bit 1) sets its status on the selected edge of the synchronised input: rising for polarity 1, falling for polarity 0. The status then holds until it is cleared. Changing the polarity while the input is stable does not set it.
- R4: Writing an input number to 0x28 sets that input's enable, and writing it to 0x2C clears it. Values of NUM_IRQ or more are ignored. Enables read back at 0x380+4n, with bit i%32 for input i.
- R5: Writing to 0x380+4n clears each enable whose data bit is 1. Data bits that are 0 leave their enables unchanged.
- R6: Writing an input number to 0x24, or writing 1 bits to 0x280+4n, clears the latched status of edge-type inputs.
  - Values of NUM_IRQ or more written to 0x24 are ignored.
  - A level-type input's status keeps following its input after such a write.
- R7: Channel-map word 0x400+4n holds the channel of input 4n+k in bits 8k+7..8k, and reads back the same way.
- R8: The winner is the candidate (status and enable both 1) with the lowest channel value. Among equal channels, the lowest input number wins. Inputs that are pending but not enabled never win.
- R9: A read of 0x80 returns the winner number in bits 9:0 with bit 31 clear. When there is no candidate it returns exactly 0x80000000.
- R10: `host_irq` is 1 exactly when all three of these hold:
  - global-enable bit 0 at 0x10 is 1;
  - host line 0 is enabled (write 0 to 0x34 to set it, write 0 to 0x38 to clear it; other values are ignored);
  - at least one candidate exists.
- R11: The words at 0x04 and 0x0C store and read back all 32 bits and have no other effect.
- R12: Polarity words at 0xD00+4n and type words at 0xD80+4n hold one bit per input (bit i%32 for input i), are written whole and read back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | NUM_IRQ | System interrupt inputs, asynchronous |
| bus_addr | input | 12 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high |
| host_irq | output | 1 | Prioritized host interrupt request |

## Verification
The bound checker watches the output side on every cycle:
- `host_irq` never rises while the global enable is off, and never rises without a winner;
- a reported winner is always pending and enabled, and no candidate has a lower channel, or an equal channel and a lower number;
- an edge-latched status never drops without a clear;
- an indexed enable write always lands.

Only the bench scenarios can show the mapping from bus writes to state. That covers byte and bit positions in the channel and bitmask words, the handling of out-of-range index values, and the input side: falling-edge capture, the absence of a false capture when polarity changes, and level status that clears cannot remove.

// File: rtl/idx_intc_pkg.sv
package idx_intc_pkg;
  localparam int ADDR_W = 12;
  localparam int CH_W   = 8;

  localparam logic [ADDR_W-1:0] A_CTRL      = 12'h004;
  localparam logic [ADDR_W-1:0] A_HCTRL     = 12'h00C;
  localparam logic [ADDR_W-1:0] A_GLOB      = 12'h010;
  localparam logic [ADDR_W-1:0] A_STAT_IDX  = 12'h024;
  localparam logic [ADDR_W-1:0] A_EN_SET    = 12'h028;
  localparam logic [ADDR_W-1:0] A_EN_CLR    = 12'h02C;
  localparam logic [ADDR_W-1:0] A_HOST_SET  = 12'h034;
  localparam logic [ADDR_W-1:0] A_HOST_CLR  = 12'h038;
  localparam logic [ADDR_W-1:0] A_WINNER    = 12'h080;
  localparam logic [ADDR_W-1:0] B_STAT_MASK = 12'h280;
  localparam logic [ADDR_W-1:0] B_EN_MASK   = 12'h380;
  localparam logic [ADDR_W-1:0] B_CHAN      = 12'h400;
  localparam logic [ADDR_W-1:0] B_POL       = 12'hD00;
  localparam logic [ADDR_W-1:0] B_TYPE      = 12'hD80;

  localparam logic [CH_W-1:0] CHAN_DEFAULT = 8'd7;

  // byte address of the n-th word of a banked register
  function automatic logic [ADDR_W-1:0] word_addr(input logic [ADDR_W-1:0] base, input int n);
    return base + ADDR_W'(n * 4);
  endfunction

  // true when channel a outranks the best so far (b), or no best exists yet
  function automatic logic chan_beats(input logic [CH_W-1:0] a, input logic [CH_W-1:0] b,
                                      input logic have_b);
    return !have_b || (a < b);
  endfunction
endpackage

// File: rtl/idx_intc_src.sv
module idx_intc_src (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_raw,
  input  logic act_high,
  input  logic is_edge,
  input  logic clr,
  output logic status,
  output logic edge_hit
);
  logic s1_q, s2_q, s3_q, latch_q;

  assign edge_hit = (s2_q != s3_q) && (s2_q == act_high);
  assign status   = is_edge ? latch_q : (s2_q == act_high);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q    <= 1'b0;
      s2_q    <= 1'b0;
      s3_q    <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      s1_q    <= irq_raw;
      s2_q    <= s1_q;
      s3_q    <= s2_q;
      latch_q <= is_edge & (edge_hit | (latch_q & ~clr));
    end
  end
endmodule

// File: rtl/idx_intc_arb.sv
module idx_intc_arb import idx_intc_pkg::*; #(
  parameter int NUM_IRQ = 64,
  parameter int SRC_W   = 6
) (
  input  logic [NUM_IRQ-1:0]           cand,
  input  logic [NUM_IRQ-1:0][CH_W-1:0] chan,
  output logic                         none,
  output logic [SRC_W-1:0]             win
);
  logic            found;
  logic [CH_W-1:0] best;

  always_comb begin
    found = 1'b0;
    best  = '1;
    win   = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (cand[i] && chan_beats(chan[i], best, found)) begin
        found = 1'b1;
        best  = chan[i];
        win   = SRC_W'(i);
      end
    end
    none = !found;
  end
endmodule

// File: rtl/idx_intc.sv
module idx_intc import idx_intc_pkg::*; #(
  parameter int NUM_IRQ  = 64,
  parameter int IDX_BITS = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic [11:0]        bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               host_irq
);
  localparam int SRC_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  logic [NUM_IRQ-1:0]           en_q, pol_q, edge_q;
  logic [NUM_IRQ-1:0][CH_W-1:0] chan_q;
  logic                         glob_en_q, host_en_q;
  logic [31:0]                  ctrl_q, hctrl_q;
  logic [NUM_IRQ-1:0]           stat, clr_vec, cand, edge_hit;
  logic [SRC_W-1:0]             win_idx;
  logic                         win_none;
  logic                         idx_ok;
  logic [SRC_W-1:0]             idx;
  logic [31:0]                  rdata_c;

  assign idx_ok = (bus_wdata < 32'(NUM_IRQ));
  assign idx    = bus_wdata[SRC_W-1:0];

  // status-clear strobes: indexed write or bitmask write-one
  always_comb begin
    for (int i = 0; i < NUM_IRQ; i++) begin
      clr_vec[i] = bus_wr &&
        (((bus_addr == A_STAT_IDX) && idx_ok && (idx == SRC_W'(i))) ||
         ((bus_addr == word_addr(B_STAT_MASK, i / 32)) && bus_wdata[i % 32]));
    end
  end

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_src
    idx_intc_src u_src (
      .clk      (clk),
      .rst_n    (rst_n),
      .irq_raw  (irq_in[g]),
      .act_high (pol_q[g]),
      .is_edge  (edge_q[g]),
      .clr      (clr_vec[g]),
      .status   (stat[g]),
      .edge_hit (edge_hit[g])
    );
  end

  assign cand = stat & en_q;

  idx_intc_arb #(.NUM_IRQ(NUM_IRQ), .SRC_W(SRC_W)) u_arb (
    .cand (cand),
    .chan (chan_q),
    .none (win_none),
    .win  (win_idx)
  );

  assign host_irq = glob_en_q & host_en_q & ~win_none;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= '0;
      pol_q     <= '1;
      edge_q    <= '0;
      glob_en_q <= 1'b0;
      host_en_q <= 1'b0;
      ctrl_q    <= '0;
      hctrl_q   <= '0;
      for (int i = 0; i < NUM_IRQ; i++) chan_q[i] <= CHAN_DEFAULT;
    end else if (bus_wr) begin
      if (bus_addr == A_CTRL)  ctrl_q    <= bus_wdata;
      if (bus_addr == A_HCTRL) hctrl_q   <= bus_wdata;
      if (bus_addr == A_GLOB)  glob_en_q <= bus_wdata[0];
      if (bus_addr == A_HOST_SET && bus_wdata == 32'd0) host_en_q <= 1'b1;
      if (bus_addr == A_HOST_CLR && bus_wdata == 32'd0) host_en_q <= 1'b0;
      for (int i = 0; i < NUM_IRQ; i++) begin
        if (bus_addr == A_EN_SET && idx_ok && idx == SRC_W'(i)) en_q[i] <= 1'b1;
        if (bus_addr == A_EN_CLR && idx_ok && idx == SRC_W'(i)) en_q[i] <= 1'b0;
        if (bus_addr == word_addr(B_EN_MASK, i / 32) && bus_wdata[i % 32]) en_q[i] <= 1'b0;
        if (bus_addr == word_addr(B_POL, i / 32))  pol_q[i]  <= bus_wdata[i % 32];
        if (bus_addr == word_addr(B_TYPE, i / 32)) edge_q[i] <= bus_wdata[i % 32];
        if (bus_addr == word_addr(B_CHAN, i / 4))  chan_q[i] <= bus_wdata[8*(i%4) +: 8];
      end
    end
  end

  always_comb begin
    rdata_c = '0;
    if (bus_addr == A_CTRL)  rdata_c = ctrl_q;
    if (bus_addr == A_HCTRL) rdata_c = hctrl_q;
    if (bus_addr == A_GLOB)  rdata_c[0] = glob_en_q;
    if (bus_addr == A_WINNER) begin
      rdata_c[31] = win_none;
      if (!win_none) rdata_c[IDX_BITS-1:0] = IDX_BITS'(win_idx);
    end
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (bus_addr == word_addr(B_STAT_MASK, i / 32)) rdata_c[i % 32] = stat[i];
      if (bus_addr == word_addr(B_EN_MASK, i / 32))   rdata_c[i % 32] = en_q[i];
      if (bus_addr == word_addr(B_POL, i / 32))       rdata_c[i % 32] = pol_q[i];
      if (bus_addr == word_addr(B_TYPE, i / 32))      rdata_c[i % 32] = edge_q[i];
      if (bus_addr == word_addr(B_CHAN, i / 4))       rdata_c[8*(i%4) +: 8] = chan_q[i];
    end
  end

  assign bus_rdata = bus_rd ? rdata_c : 32'd0;
endmodule

// File: rtl/idx_intc_chk.sv
module idx_intc_chk import idx_intc_pkg::*; #(
  parameter int NUM_IRQ = 64,
  parameter int SRC_W   = 6
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         bus_wr,
  input logic [11:0]                  bus_addr,
  input logic [31:0]                  bus_wdata,
  input logic                         host_irq,
  input logic                         glob_en_q,
  input logic [NUM_IRQ-1:0]           stat,
  input logic [NUM_IRQ-1:0]           en_q,
  input logic [NUM_IRQ-1:0]           edge_q,
  input logic [NUM_IRQ-1:0]           clr_vec,
  input logic [NUM_IRQ-1:0][CH_W-1:0] chan_q,
  input logic [SRC_W-1:0]             win_idx,
  input logic                         win_none
);
  assert_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en_q |-> !host_irq);

  assert_irq_has_winner_R10: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> !win_none);

  assert_none_means_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    win_none |-> ((stat & en_q) == '0));

  assert_winner_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !win_none |-> (stat[win_idx] && en_q[win_idx]));

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_chk
    assert_prio_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (stat[g] && en_q[g] && !win_none) |->
        ((chan_q[g] > chan_q[win_idx]) ||
         ((chan_q[g] == chan_q[win_idx]) && (SRC_W'(g) >= win_idx))));

    assert_edge_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_q[g] && stat[g] && !clr_vec[g]) |=> (stat[g] || !edge_q[g]));

    assert_idx_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_EN_SET && bus_wdata == 32'(g)) |=> en_q[g]);
  end
endmodule

bind idx_intc idx_intc_chk #(.NUM_IRQ(NUM_IRQ), .SRC_W(SRC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .host_irq  (host_irq),
  .glob_en_q (glob_en_q),
  .stat      (stat),
  .en_q      (en_q),
  .edge_q    (edge_q),
  .clr_vec   (clr_vec),
  .chan_q    (chan_q),
  .win_idx   (win_idx),
  .win_none  (win_none)
);

// File: tb/idx_intc_tb.sv
module idx_intc_tb;
  localparam int N = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] irq_v = '0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, probe = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        host_irq;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
    bit          is_irq;
  } item_t;
  item_t sb_q[$];

  always #2 clk = ~clk;

  idx_intc #(.NUM_IRQ(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_v), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .host_irq(host_irq)
  );

  // monitor: compares results mid-cycle against the scoreboard
  always @(negedge clk) begin
    if (bus_rd || probe) begin
      if (sb_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL scoreboard underflow act=%h exp=<none>", bus_rdata);
      end else begin
        item_t it;
        logic [31:0] act;
        it  = sb_q.pop_front();
        act = it.is_irq ? {31'd0, host_irq} : bus_rdata;
        n_cmp++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s act=%h exp=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    cyc(); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    cyc(); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    item_t it;
    cyc(); bus_addr = a; bus_rd = 1'b1;
    it.exp = e; it.tag = tag; it.is_irq = 1'b0; sb_q.push_back(it);
    cyc(); bus_rd = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    item_t it;
    cyc(); probe = 1'b1;
    it.exp = {31'd0, e}; it.tag = tag; it.is_irq = 1'b1; sb_q.push_back(it);
    cyc(); probe = 1'b0;
  endtask

  task automatic drive(input int i, input logic v);
    cyc(); irq_v[i] = v;
    repeat (5) cyc();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(12'h080, 32'h8000_0000, "R1 winner none after reset");
    rd(12'h380, 32'h0, "R1 enables zero");
    rd(12'h400, 32'h0707_0707, "R1 default channel 7");
    rd(12'hD00, 32'hFFFF_FFFF, "R1 polarity high");
    rd(12'hD80, 32'h0, "R1 type level");
    chk_irq(1'b0, "R1 host_irq low");

    // R11 plain storage
    wr(12'h004, 32'hA5A5_1234); rd(12'h004, 32'hA5A5_1234, "R11 ctrl store");
    wr(12'h00C, 32'h0000_5A5A); rd(12'h00C, 32'h0000_5A5A, "R11 host ctrl store");
    rd(12'h080, 32'h8000_0000, "R11 no side effect");

    // R2 level status
    drive(5, 1'b1); rd(12'h280, 32'h20, "R2 level high seen");
    drive(5, 1'b0); rd(12'h280, 32'h0, "R2 level drops");
    wr(12'hD00, 32'hFFFF_FFF7);
    rd(12'hD00, 32'hFFFF_FFF7, "R12 polarity readback");
    repeat (3) cyc();
    rd(12'h280, 32'h8, "R2 active-low level");
    wr(12'hD00, 32'hFFFF_FFFF);
    rd(12'h280, 32'h0, "R2 polarity restored");

    // R4 / R5 enables
    wr(12'h028, 5); wr(12'h028, 40); wr(12'h028, 64); wr(12'h028, 1000);
    rd(12'h380, 32'h20, "R4 indexed set low word");
    rd(12'h384, 32'h100, "R4 indexed set high word, out-of-range ignored");
    wr(12'h02C, 5); rd(12'h380, 32'h0, "R4 indexed clear");
    wr(12'h028, 5); wr(12'h028, 6);
    wr(12'h380, 32'h40); rd(12'h380, 32'h20, "R5 bitmask clear one bit");
    wr(12'h384, 32'h0);  rd(12'h384, 32'h100, "R5 zero bits no effect");

    // R3 rising edge on input 40
    wr(12'hD84, 32'h100); rd(12'hD84, 32'h100, "R12 type readback");
    drive(40, 1'b1); rd(12'h284, 32'h100, "R3 rising captured");
    drive(40, 1'b0); rd(12'h284, 32'h100, "R3 status held after input falls");
    rd(12'h080, 32'd40, "R9 winner index 40");

    // R10 host gating
    chk_irq(1'b0, "R10 global off");
    wr(12'h010, 32'h1); chk_irq(1'b0, "R10 host line off");
    wr(12'h034, 32'd3); chk_irq(1'b0, "R10 host index 3 ignored");
    wr(12'h034, 32'd0); chk_irq(1'b1, "R10 all enabled");

    // R6 status clear
    wr(12'h024, 64); rd(12'h284, 32'h100, "R6 out-of-range clear ignored");
    wr(12'h024, 40); rd(12'h284, 32'h0, "R6 indexed clear");
    rd(12'h080, 32'h8000_0000, "R9 none after clear");
    chk_irq(1'b0, "R10 no candidate");

    // R3 falling edge, no false capture on polarity change
    wr(12'hD04, 32'hFFFF_FEFF);
    repeat (3) cyc();
    rd(12'h284, 32'h0, "R3 polarity change no capture");
    drive(40, 1'b1); rd(12'h284, 32'h0, "R3 rising ignored when falling selected");
    drive(40, 1'b0); rd(12'h284, 32'h100, "R3 falling captured");
    wr(12'h284, 32'h100); rd(12'h284, 32'h0, "R6 bitmask clear");

    // R6 level status survives clears
    drive(5, 1'b1);
    wr(12'h280, 32'h20); rd(12'h280, 32'h20, "R6 level unaffected by clear");
    rd(12'h080, 32'd5, "R8 only candidate 5");

    // R8 / R7 priority
    drive(40, 1'b1); drive(40, 1'b0);
    rd(12'h080, 32'd5, "R8 tie on channel 7 lowest number");
    wr(12'h428, 32'h0707_0703); rd(12'h428, 32'h0707_0703, "R7 channel word readback");
    rd(12'h080, 32'd40, "R8 lower channel wins");
    wr(12'h40C, 32'h0707_0700); drive(12, 1'b1);
    rd(12'h080, 32'd40, "R8 pending but disabled ignored");
    wr(12'h028, 12); rd(12'h080, 32'd12, "R8 channel 0 wins");
    wr(12'h404, 32'h0707_0007);
    rd(12'h080, 32'd5, "R7 byte1 maps input 5, tie lowest");
    chk_irq(1'b1, "R10 asserted with winner");
    wr(12'h038, 32'd0); chk_irq(1'b0, "R10 host line cleared");
    wr(12'h034, 32'd0); wr(12'h010, 32'h0); chk_irq(1'b0, "R10 global cleared");

    repeat (4) cyc();
    if (sb_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL scoreboard leftover act=%0d exp=0", sb_q.size());
    end
    finish_run();
  end
endmodule